// File: doc/BRIEF.md
# Heat Diffusion Column Engine

This block advances one column of a two-dimensional explicit heat-diffusion grid by one time step. The column's temperatures sit in a private single-port RAM, one signed fixed-point word per row. A step is launched by `start`. The engine then visits the rows from top to bottom. For each row it forms the five-point stencil from three sources: the row's own old value, the old values of the rows above and below (taken from its own RAM), and the old values of the same row in the two sibling columns (taken from `left_in`/`right_in`). It writes the result back in place and presents it on `new_val`. The engine then stalls until `adv` is pulsed, which gives a display or collection path time to consume each result.

Many instances run side by side in lockstep. Each instance drives `nbr_out` with its own old value of the current row, and that signal feeds the neighbour inputs of the adjacent columns. Up to two cells can be fixed at elaboration: a source and a sink, each with its own row and value. These cells keep their value on every step. While the engine is idle, a controller may overwrite any other row through a heat-injection write port.

Top module: `heat_col_engine`

## Requirements
- R1: After reset is released, the engine fills the RAM over ROWS cycles. Fixed rows get their fixed value and every other row gets 0. The engine then pulses `done` for one cycle, enters idle, and holds `row_valid` low throughout.
- R2: Apart from fixed rows, each row's result is `old + ((K*(up+down+left+right-4*old)) >>> FRAC)`, truncated to W bits. All values are two's-complement with FRAC fraction bits, and `>>>` rounds toward minus infinity.
- R3: `up` and `down` are the column's own values from the previous step. A row outside the column counts as 0. `left`/`right` are the values on `left_in`/`right_in` during that row's computation.
- R4: A fixed source or sink row always produces its fixed value and keeps that value in RAM.
- R5: While `row_valid` is high and `adv` is low, `new_val`, `row_idx` and `row_valid` hold.
- R6: Rows are produced in the order 0, 1, …, ROWS-1. `row_idx` gives the row whose result is on `new_val`. After an `adv` on any row except the last, `row_valid` drops for exactly one cycle.
- R7: The update is done in place, yet every row reads only previous-step values. An already-rewritten upper row never feeds the row below it.
- R8: An `adv` on the last row pulses `done` for exactly one cycle in the next cycle and returns the engine to idle. A further step needs a new `start`. An `adv` while idle has no effect.
- R9: A write with `inj_we` while idle stores `inj_val` into row `inj_row`. The write is ignored during a step and ignored on fixed rows.
- R10: While `row_valid` is high, `nbr_out` equals the previous-step value of row `row_idx`.
- R11: A `start` during a step, or during the initial fill, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin one time step while idle |
| adv | input | 1 | Release the stall after a row result |
| left_in | input | W | Previous-step value of the current row in the left column |
| right_in | input | W | Previous-step value of the current row in the right column |
| inj_we | input | 1 | Heat-injection write strobe |
| inj_row | input | $clog2(ROWS) | Row targeted by the injection |
| inj_val | input | W | Value written by the injection |
| new_val | output | W | Newly computed value of row `row_idx` |
| row_idx | output | $clog2(ROWS) | Row whose result is presented |
| row_valid | output | 1 | Row result presented, engine stalled |
| done | output | 1 | One-cycle pulse at end of initial fill and of each step |
| nbr_out | output | W | Own previous-step value of the current row, for sibling columns |

## Verification
Several internal faults show up at the ports within one row of the step in which they occur. A wrong shift of the held upper-row register, or reading a rewritten RAM word, produces an incorrect `new_val` on the very next row. A wrong row counter or a wrong RAM read address shows as an out-of-order `row_idx` or a mismatched `nbr_out` on the first row of a step. An error in the fill or the injection path stays in RAM without being seen until the next step, where it appears in the stored row and in both of its vertical neighbours. The bench therefore runs consecutive steps with different neighbour patterns, and it compares every row of every step against a model of the whole column.

// File: rtl/heat_col_pkg.sv
package heat_col_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_PRIME,
    ST_LOAD,
    ST_WAIT
  } col_state_e;

  typedef enum logic [1:0] {
    WS_FILL,
    WS_INJ,
    WS_CALC
  } wsel_e;

endpackage

// File: rtl/heat_col_ram.sv
module heat_col_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // read data changes only on a read access; a write leaves it untouched
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/heat_col_stencil.sv
module heat_col_stencil #(
  parameter int W    = 32,
  parameter int FRAC = 16,
  parameter int KW   = 18,
  parameter int K    = 16384
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] up,
  input  logic [W-1:0] down,
  input  logic [W-1:0] left,
  input  logic [W-1:0] right,
  output logic [W-1:0] nxt
);

  localparam int LW = W + 3;
  localparam int PW = LW + KW;
  localparam logic [KW-1:0] KS = KW'(K);

  logic [LW-1:0]        lap;
  logic [PW-1:0]        lap_x;
  logic [PW-1:0]        k_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] delta;

  always_comb begin
    lap = {{3{up[W-1]}}, up} + {{3{down[W-1]}}, down}
        + {{3{left[W-1]}}, left} + {{3{right[W-1]}}, right}
        - {cur[W-1], cur, 2'b00};
    lap_x = {{KW{lap[LW-1]}}, lap};
    k_x   = {{LW{KS[KW-1]}}, KS};
    prod  = lap_x * k_x;
    delta = prod >>> FRAC;
    nxt   = cur + delta[W-1:0];
  end

endmodule

// File: rtl/heat_col_ctrl.sv
module heat_col_ctrl
  import heat_col_pkg::*;
#(
  parameter int ROWS = 64,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          inj_we,
  input  logic [RW-1:0] inj_row,
  input  logic          inj_fixed,
  output logic          ram_en,
  output logic          ram_we,
  output logic [RW-1:0] ram_addr,
  output wsel_e         wsel,
  output logic          prime_ld,
  output logic          shift_ld,
  output logic          new_ld,
  output logic [RW-1:0] row,
  output logic          row_valid,
  output logic          done,
  output logic          last_row
);

  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  col_state_e    state_q, state_d;
  logic [RW-1:0] row_q, row_d;
  logic          done_q, done_d;

  assign last_row  = (row_q == LAST);
  assign row       = row_q;
  assign row_valid = (state_q == ST_WAIT);
  assign done      = done_q;

  always_comb begin
    state_d  = state_q;
    row_d    = row_q;
    done_d   = 1'b0;
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = row_q;
    wsel     = WS_CALC;
    prime_ld = 1'b0;
    shift_ld = 1'b0;
    new_ld   = 1'b0;
    case (state_q)
      ST_INIT: begin
        ram_en = 1'b1;
        ram_we = 1'b1;
        wsel   = WS_FILL;
        if (last_row) begin
          row_d   = '0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          row_d = row_q + RW'(1);
        end
      end
      ST_IDLE: begin
        if (start) begin
          ram_en   = 1'b1;
          ram_addr = '0;
          row_d    = '0;
          state_d  = ST_PRIME;
        end else if (inj_we && !inj_fixed) begin
          ram_en   = 1'b1;
          ram_we   = 1'b1;
          ram_addr = inj_row;
          wsel     = WS_INJ;
        end
      end
      ST_PRIME: begin
        prime_ld = 1'b1;
        ram_en   = 1'b1;
        ram_addr = RW'(1);
        state_d  = ST_LOAD;
      end
      ST_LOAD: begin
        ram_en  = 1'b1;
        ram_we  = 1'b1;
        new_ld  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (adv) begin
          if (last_row) begin
            done_d  = 1'b1;
            row_d   = '0;
            state_d = ST_IDLE;
          end else begin
            shift_ld = 1'b1;
            row_d    = row_q + RW'(1);
            state_d  = ST_LOAD;
            if (int'(row_q) + 2 < ROWS) begin
              ram_en   = 1'b1;
              ram_addr = RW'(int'(row_q) + 2);
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/heat_col_engine.sv
module heat_col_engine
  import heat_col_pkg::*;
#(
  parameter int ROWS    = 64,
  parameter int W       = 32,
  parameter int FRAC    = 16,
  parameter int KW      = 18,
  parameter int K       = 16384,
  parameter bit SRC_EN  = 1'b1,
  parameter int SRC_ROW = 32,
  parameter int SRC_VAL = 8 << 16,
  parameter bit SNK_EN  = 1'b0,
  parameter int SNK_ROW = 7,
  parameter int SNK_VAL = 0,
  localparam int RW     = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [W-1:0]  left_in,
  input  logic [W-1:0]  right_in,
  input  logic          inj_we,
  input  logic [RW-1:0] inj_row,
  input  logic [W-1:0]  inj_val,
  output logic [W-1:0]  new_val,
  output logic [RW-1:0] row_idx,
  output logic          row_valid,
  output logic          done,
  output logic [W-1:0]  nbr_out
);

  localparam logic [W-1:0] SRC_W = W'(SRC_VAL);
  localparam logic [W-1:0] SNK_W = W'(SNK_VAL);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  logic          ram_en, ram_we;
  logic [RW-1:0] ram_addr;
  wsel_e         wsel;
  logic          prime_ld, shift_ld, new_ld, last_row;
  logic [RW-1:0] row;
  logic [W-1:0]  rdata, wdata;
  logic          src_row, snk_row, src_inj, snk_inj, inj_fixed;

  // fixed-cell decode, present only for the enabled variants
  generate
    if (SRC_EN) begin : g_src
      assign src_row = (row == RW'(SRC_ROW));
      assign src_inj = (inj_row == RW'(SRC_ROW));
    end else begin : g_nosrc
      assign src_row = 1'b0;
      assign src_inj = 1'b0;
    end
    if (SNK_EN) begin : g_snk
      assign snk_row = (row == RW'(SNK_ROW));
      assign snk_inj = (inj_row == RW'(SNK_ROW));
    end else begin : g_nosnk
      assign snk_row = 1'b0;
      assign snk_inj = 1'b0;
    end
  endgenerate

  assign inj_fixed = src_inj | snk_inj;

  heat_col_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start),
    .adv      (adv),
    .inj_we   (inj_we),
    .inj_row  (inj_row),
    .inj_fixed(inj_fixed),
    .ram_en   (ram_en),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .wsel     (wsel),
    .prime_ld (prime_ld),
    .shift_ld (shift_ld),
    .new_ld   (new_ld),
    .row      (row),
    .row_valid(row_valid),
    .done     (done),
    .last_row (last_row)
  );

  heat_col_ram #(.DEPTH(ROWS), .W(W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(wdata),
    .rdata(rdata)
  );

  // held old values: row above (already rewritten in RAM) and current row
  logic [W-1:0] prev_q, cur_q, new_q;
  logic [W-1:0] down_v, stencil_v, calc_v, fixed_v;

  assign down_v  = last_row ? '0 : rdata;
  assign fixed_v = src_row ? SRC_W : SNK_W;

  heat_col_stencil #(.W(W), .FRAC(FRAC), .KW(KW), .K(K)) u_stencil (
    .cur  (cur_q),
    .up   (prev_q),
    .down (down_v),
    .left (left_in),
    .right(right_in),
    .nxt  (stencil_v)
  );

  assign calc_v = (src_row | snk_row) ? fixed_v : stencil_v;

  always_comb begin
    case (wsel)
      WS_FILL: wdata = (src_row | snk_row) ? fixed_v : '0;
      WS_INJ:  wdata = inj_val;
      default: wdata = calc_v;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prev_q <= '0;
      cur_q  <= '0;
      new_q  <= '0;
    end else begin
      if (prime_ld) begin
        prev_q <= '0;
        cur_q  <= rdata;
      end else if (shift_ld) begin
        prev_q <= cur_q;
        cur_q  <= rdata;
      end
      if (new_ld) begin
        new_q <= calc_v;
      end
    end
  end

  assign new_val = new_q;
  assign row_idx = row;
  assign nbr_out = cur_q;

endmodule

// File: rtl/heat_col_engine_chk.sv
module heat_col_engine_chk #(
  parameter int ROWS    = 64,
  parameter int W       = 32,
  parameter bit SRC_EN  = 1'b1,
  parameter int SRC_ROW = 32,
  parameter int SRC_VAL = 8 << 16,
  parameter bit SNK_EN  = 1'b0,
  parameter int SNK_ROW = 7,
  parameter int SNK_VAL = 0,
  localparam int RW     = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv,
  input logic          row_valid,
  input logic [RW-1:0] row_idx,
  input logic [W-1:0]  new_val,
  input logic          done,
  input logic [W-1:0]  nbr_out
);

  localparam logic [RW-1:0] LAST  = RW'(ROWS - 1);
  localparam logic [W-1:0]  SRC_W = W'(SRC_VAL);
  localparam logic [W-1:0]  SNK_W = W'(SNK_VAL);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && !adv |=> row_valid && $stable(new_val) && $stable(row_idx));

  // R6
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && adv && row_idx != LAST |=> !row_valid && !done);

  // R8
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && adv && row_idx == LAST |=> done && !row_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SRC_EN && row_valid && row_idx == RW'(SRC_ROW) |-> new_val == SRC_W);

  // R4
  snk_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SNK_EN && row_valid && row_idx == RW'(SNK_ROW) |-> new_val == SNK_W);

  // R10
  nbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid && !adv |=> $stable(nbr_out));

endmodule

bind heat_col_engine heat_col_engine_chk #(
  .ROWS(ROWS), .W(W), .SRC_EN(SRC_EN), .SRC_ROW(SRC_ROW), .SRC_VAL(SRC_VAL),
  .SNK_EN(SNK_EN), .SNK_ROW(SNK_ROW), .SNK_VAL(SNK_VAL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv      (adv),
  .row_valid(row_valid),
  .row_idx  (row_idx),
  .new_val  (new_val),
  .done     (done),
  .nbr_out  (nbr_out)
);

// File: tb/heat_col_engine_bench.sv
module heat_col_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS    = 8;
  localparam int RW      = $clog2(ROWS);
  localparam int W       = 32;
  localparam int FRAC    = 16;
  localparam int K       = 16384;
  localparam int SRC_ROW = 2;
  localparam int SRC_VAL = 8 << 16;
  localparam int SNK_ROW = 5;
  localparam int SNK_VAL = -(2 << 16);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          adv = 1'b0;
  logic [W-1:0]  left_in = '0;
  logic [W-1:0]  right_in = '0;
  logic          inj_we = 1'b0;
  logic [RW-1:0] inj_row = '0;
  logic [W-1:0]  inj_val = '0;
  logic [W-1:0]  new_val;
  logic [RW-1:0] row_idx;
  logic          row_valid;
  logic          done;
  logic [W-1:0]  nbr_out;

  int n_chk = 0;
  int n_fail = 0;
  int model [ROWS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  heat_col_engine #(
    .ROWS(ROWS), .W(W), .FRAC(FRAC), .KW(18), .K(K),
    .SRC_EN(1'b1), .SRC_ROW(SRC_ROW), .SRC_VAL(SRC_VAL),
    .SNK_EN(1'b1), .SNK_ROW(SNK_ROW), .SNK_VAL(SNK_VAL)
  ) u_heat_col_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .left_in(left_in), .right_in(right_in),
    .inj_we(inj_we), .inj_row(inj_row), .inj_val(inj_val),
    .new_val(new_val), .row_idx(row_idx), .row_valid(row_valid),
    .done(done), .nbr_out(nbr_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int stencil_m(input int c, input int u, input int d, input int l, input int r);
    longint lap = longint'(u) + longint'(d) + longint'(l) + longint'(r) - 4 * longint'(c);
    longint p = lap * longint'(K);
    longint dl = p >>> FRAC;
    return int'(longint'(c) + dl);
  endfunction

  function automatic int lval(input int r, input int pat);
    if (pat == 0) return 0;
    if (pat == 1) return (r * 7 + 3) << 13;
    return -((r + 5) << 15);
  endfunction

  function automatic int rval(input int r, input int pat);
    if (pat == 0) return 0;
    if (pat == 1) return -((r + 1) << 12);
    return (ROWS - r) << 16;
  endfunction

  task automatic set_lr(input int r, input int pat);
    left_in  = lval(r, pat);
    right_in = rval(r, pat);
  endtask

  task automatic wait_valid();
    for (int n = 0; n < 20 && !row_valid; n++) @(negedge clk);
  endtask

  task automatic inject(input int r, input int v);
    @(negedge clk);
    inj_we = 1'b1; inj_row = RW'(r); inj_val = v;
    @(negedge clk);
    inj_we = 1'b0;
  endtask

  // one full time step, checking every row against the model
  task automatic run_step(input int pat, input bit poke);
    int nxt [ROWS];
    int exp_v;
    set_lr(0, pat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      wait_valid();
      chk(row_valid == 1'b1, "R6 row presented", row_valid, 1);
      chk(row_idx == RW'(r), "R6 row order", row_idx, r);
      chk($signed(nbr_out) == model[r], "R10 neighbour output", $signed(nbr_out), model[r]);
      if (r == SRC_ROW) exp_v = SRC_VAL;
      else if (r == SNK_ROW) exp_v = SNK_VAL;
      else exp_v = stencil_m(model[r], (r > 0) ? model[r-1] : 0,
                             (r < ROWS - 1) ? model[r+1] : 0, lval(r, pat), rval(r, pat));
      nxt[r] = exp_v;
      if (r == SRC_ROW || r == SNK_ROW)
        chk($signed(new_val) == exp_v, "R4 fixed cell", $signed(new_val), exp_v);
      else
        chk($signed(new_val) == exp_v, "R2 R3 R7 stencil", $signed(new_val), exp_v);
      if (poke && r == 3) begin
        // stray start and injection mid-step must be ignored (R9, R11)
        start = 1'b1; inj_we = 1'b1; inj_row = RW'(4); inj_val = 32'h7fff_0000;
        @(negedge clk);
        start = 1'b0; inj_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(row_valid == 1'b1 && $signed(new_val) == exp_v, "R5 stall hold", $signed(new_val), exp_v);
        chk(row_idx == RW'(r), "R5 index hold", row_idx, r);
      end
      if (r < ROWS - 1) set_lr(r + 1, pat);
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
      if (r == ROWS - 1) begin
        chk(done == 1'b1, "R8 done after last row", done, 1);
        chk(row_valid == 1'b0, "R8 idle after step", row_valid, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
      end else begin
        chk(row_valid == 1'b0, "R6 valid drops after adv", row_valid, 0);
      end
    end
    for (int r = 0; r < ROWS; r++) model[r] = nxt[r];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    for (int r = 0; r < ROWS; r++) model[r] = 0;
    model[SRC_ROW] = SRC_VAL;
    model[SNK_ROW] = SNK_VAL;
    repeat (3) @(negedge clk);
    chk(row_valid == 1'b0 && done == 1'b0, "R1 reset state", {row_valid, done}, 0);
    rst_n = 1'b1;
    // R11: start during the fill must not begin a step
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int n = 0; n < ROWS + 10 && !seen; n++) begin
      @(negedge clk);
      chk(row_valid == 1'b0, "R1 R11 no row during fill", row_valid, 0);
      if (done) seen = 1'b1;
    end
    chk(seen, "R1 fill done pulse", seen, 1);
    @(negedge clk);
    chk(done == 1'b0, "R1 done one cycle", done, 0);
    // R8: adv while idle does nothing
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
    repeat (3) @(negedge clk);
    chk(row_valid == 1'b0 && done == 1'b0, "R8 idle adv ignored", {row_valid, done}, 0);

    run_step(0, 1'b0);
    // R9: idle injection on a plain row, ignored on the fixed rows
    inject(6, 3 << 16);
    model[6] = 3 << 16;
    inject(SRC_ROW, 12345);
    inject(SNK_ROW, 777);
    run_step(1, 1'b1);
    inject(0, -(5 << 16));
    model[0] = -(5 << 16);
    inject(ROWS - 1, 9 << 16);
    model[ROWS - 1] = 9 << 16;
    run_step(2, 1'b0);
    run_step(1, 1'b1);
    run_step(0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule